// File: doc/BRIEF.md
# Two-Bit Logic Slice with Parallel Select Mode

This block models one two-bit slice of a programmable fabric. Each bit owns a 4-input lookup table (LUT) programmed by a 16-bit mask. Each bit also has a 4:1 multiplexer wired to the same four inputs as its LUT. A fast carry stage per bit chains the two bits from bottom to top. Each bit has a storage flip-flop with synchronous reset and clock enable. Configuration inputs set the masks, the combinational output source of each bit, the flip-flop data source, the carry generate source and the carry entry points.

The two side inputs have two roles. In normal mode each one is a private data input to the flip-flop of its bit. In select mode the pair acts as the shared select of both multiplexers, so neither one can reach a flip-flop. The flip-flops then take their bit's LUT result. A wide shifter stage packs into these slices: each bit picks one of four neighbours under a common shift amount.

Top module: `slice_cell`

## Requirements
- R1: With output source 0 (LUT), a bit's combinational output equals bit `idx` of its mask. Here `idx` is its four inputs read as a number with input 0 as the least significant bit. Source code 3 also gives the LUT result.
- R2: With output source 1 (MUX), a bit's combinational output equals its input number `{side_in[1], side_in[0]}`. Both bits use that same select.
- R3: The select function of R2 is available in both modes. Select mode changes only the flip-flop data path.
- R4: With output source 2 (SUM), a bit's combinational output equals its LUT result XOR the carry entering that bit.
- R5: A bit's carry out equals its carry in when its LUT result is 1. Otherwise it equals the generate value. The generate value is input 0 of the bit when its `cfg_gen_sel` bit is 0, and input 1 when it is 1.
- R6: The carry entering bit 0 is `carry_in`, and the carry entering bit 1 is bit 0's carry out. The exception is a bit whose `cfg_chain_entry` bit is 1: that bit takes its own side input as its carry in. `carry_out` is bit 1's carry out.
- R7: In normal mode, one clock edge after an enabled cycle, a flip-flop holds its bit's side input if its `cfg_ff_src` bit is 0. It holds its bit's LUT result if that bit is 1.
- R8: In select mode (`cfg_mux_mode`=1), an enabled flip-flop loads its bit's LUT result whatever `cfg_ff_src` says. Side input values do not reach `reg_out`.
- R9: With `ce` low and `rst` low, `reg_out` keeps its value across clock edges.
- R10: `rst` high at a clock edge clears both flip-flops to 0, whatever the value of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flip-flops |
| ce | input | 1 | Clock enable of the flip-flops |
| lut_in | input | NUM_BITS x LUT_K | Per-bit LUT and multiplexer inputs |
| side_in | input | NUM_BITS | Side inputs: flip-flop data, multiplexer select or carry injection |
| carry_in | input | 1 | Carry from the slice below |
| cfg_mask | input | NUM_BITS x 2^LUT_K | LUT truth tables |
| cfg_out_sel | input | NUM_BITS x 2 | Combinational output source: 0 LUT, 1 MUX, 2 SUM, 3 LUT |
| cfg_ff_src | input | NUM_BITS | Flip-flop source in normal mode: 0 side input, 1 LUT |
| cfg_gen_sel | input | NUM_BITS | Carry generate source: 0 input 0, 1 input 1 |
| cfg_chain_entry | input | NUM_BITS | 1 injects the side input as that bit's carry in |
| cfg_mux_mode | input | 1 | 1 selects select mode |
| comb_out | output | NUM_BITS | Combinational outputs |
| reg_out | output | NUM_BITS | Flip-flop outputs |
| carry_out | output | 1 | Carry to the slice above |

## Verification
A wrong mask index or select decode shows at `comb_out` in the same cycle, but only for the input patterns that hit the wrong entry. For this reason the bench sweeps every index and every select value. A broken carry link appears at `carry_out` or on the upper SUM output in the same cycle once a carry must ripple through a propagating bit. A flip-flop fed from the wrong source, or one that ignores enable or reset, shows a wrong `reg_out` one edge after the stimulus. Side-input changes made during select mode are held apart from LUT changes so that such a leak stays visible.

// File: rtl/slice_pkg.sv
package slice_pkg;

    typedef enum logic [1:0] {
        OUT_LUT = 2'd0,
        OUT_MUX = 2'd1,
        OUT_SUM = 2'd2,
        OUT_ALT = 2'd3
    } out_sel_e;

    typedef enum logic {
        FF_FROM_SIDE = 1'b0,
        FF_FROM_LUT  = 1'b1
    } ff_src_e;

    typedef struct packed {
        logic lut;
        logic mux;
        logic sum;
        logic cout;
    } bit_res_t;

    function automatic logic carry_step(input logic prop, input logic cin, input logic gen);
        return prop ? cin : gen;
    endfunction

    function automatic logic pick_output(input out_sel_e sel, input bit_res_t res);
        logic r;
        case (sel)
            OUT_MUX: r = res.mux;
            OUT_SUM: r = res.sum;
            default: r = res.lut;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slice_lut.sv
module slice_lut #(
    parameter int LUT_K = 4,
    localparam int MASK_W = 1 << LUT_K
) (
    input  logic [LUT_K-1:0]  lut_addr,
    input  logic [MASK_W-1:0] lut_mask,
    output logic              lut_q
);
    assign lut_q = lut_mask[lut_addr];
endmodule

// File: rtl/slice_selmux.sv
module slice_selmux #(
    parameter int LUT_K = 4,
    localparam int SEL_W = $clog2(LUT_K)
) (
    input  logic [LUT_K-1:0] mux_data,
    input  logic [SEL_W-1:0] mux_sel,
    output logic             mux_q
);
    always_comb begin
        mux_q = 1'b0;
        for (int i = 0; i < LUT_K; i++) begin
            if (mux_sel == SEL_W'(i)) mux_q = mux_data[i];
        end
    end
endmodule

// File: rtl/slice_carry_stage.sv
module slice_carry_stage (
    input  logic prop,
    input  logic cin,
    input  logic gen_a,
    input  logic gen_b,
    input  logic gen_sel,
    output logic sum,
    output logic cout
);
    import slice_pkg::*;
    logic gen;
    assign gen  = gen_sel ? gen_b : gen_a;
    assign sum  = prop ^ cin;
    assign cout = carry_step(prop, cin, gen);
endmodule

// File: rtl/slice_store.sv
module slice_store (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (ce) q <= d;
    end
endmodule

// File: rtl/slice_cell.sv
module slice_cell #(
    parameter int NUM_BITS = 2,
    parameter int LUT_K    = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  ce,
    input  logic [NUM_BITS-1:0][LUT_K-1:0]        lut_in,
    input  logic [NUM_BITS-1:0]                   side_in,
    input  logic                                  carry_in,
    input  logic [NUM_BITS-1:0][(1<<LUT_K)-1:0]   cfg_mask,
    input  logic [NUM_BITS-1:0][1:0]              cfg_out_sel,
    input  logic [NUM_BITS-1:0]                   cfg_ff_src,
    input  logic [NUM_BITS-1:0]                   cfg_gen_sel,
    input  logic [NUM_BITS-1:0]                   cfg_chain_entry,
    input  logic                                  cfg_mux_mode,
    output logic [NUM_BITS-1:0]                   comb_out,
    output logic [NUM_BITS-1:0]                   reg_out,
    output logic                                  carry_out
);
    import slice_pkg::*;

    localparam int SEL_W = $clog2(LUT_K);

    logic [SEL_W-1:0]    shared_sel;
    logic [NUM_BITS:0]   chain;
    logic [NUM_BITS-1:0] lut_val;

    assign shared_sel = side_in[SEL_W-1:0];
    assign chain[0]   = carry_in;
    assign carry_out  = chain[NUM_BITS];

    for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
        bit_res_t res;
        logic     cin_b;
        logic     ff_d;
        ff_src_e  src_b;

        slice_lut #(.LUT_K(LUT_K)) lut_i (
            .lut_addr (lut_in[b]),
            .lut_mask (cfg_mask[b]),
            .lut_q    (res.lut)
        );

        slice_selmux #(.LUT_K(LUT_K)) mux_i (
            .mux_data (lut_in[b]),
            .mux_sel  (shared_sel),
            .mux_q    (res.mux)
        );

        assign cin_b = cfg_chain_entry[b] ? side_in[b] : chain[b];

        slice_carry_stage carry_i (
            .prop    (res.lut),
            .cin     (cin_b),
            .gen_a   (lut_in[b][0]),
            .gen_b   (lut_in[b][1]),
            .gen_sel (cfg_gen_sel[b]),
            .sum     (res.sum),
            .cout    (res.cout)
        );

        assign chain[b+1] = res.cout;
        assign lut_val[b] = res.lut;
        assign comb_out[b] = pick_output(out_sel_e'(cfg_out_sel[b]), res);

        assign src_b = ff_src_e'(cfg_ff_src[b]);
        assign ff_d  = (cfg_mux_mode || src_b == FF_FROM_LUT) ? res.lut : side_in[b];

        slice_store store_i (
            .clk (clk),
            .rst (rst),
            .ce  (ce),
            .d   (ff_d),
            .q   (reg_out[b])
        );
    end

endmodule

// File: rtl/slice_cell_chk.sv
module slice_cell_chk #(
    parameter int NUM_BITS = 2,
    parameter int LUT_K    = 4
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  ce,
    input logic [NUM_BITS-1:0][LUT_K-1:0]        lut_in,
    input logic [NUM_BITS-1:0]                   side_in,
    input logic                                  carry_in,
    input logic [NUM_BITS-1:0][(1<<LUT_K)-1:0]   cfg_mask,
    input logic [NUM_BITS-1:0][1:0]              cfg_out_sel,
    input logic [NUM_BITS-1:0]                   cfg_ff_src,
    input logic [NUM_BITS-1:0]                   cfg_chain_entry,
    input logic                                  cfg_mux_mode,
    input logic [NUM_BITS-1:0]                   comb_out,
    input logic [NUM_BITS-1:0]                   reg_out,
    input logic                                  carry_out,
    input logic [NUM_BITS-1:0]                   lut_val
);
    localparam int SEL_W = $clog2(LUT_K);

    for (genvar b = 0; b < NUM_BITS; b++) begin : g_chk
        assert_lut_route_R1: assert property (@(posedge clk) disable iff (rst)
            (cfg_out_sel[b] == 2'd0) |-> (comb_out[b] == lut_val[b]));

        assert_mux_pick_R2: assert property (@(posedge clk) disable iff (rst)
            (cfg_out_sel[b] == 2'd1) |-> (comb_out[b] == lut_in[b][side_in[SEL_W-1:0]]));

        assert_side_load_R7: assert property (@(posedge clk) disable iff (rst)
            (ce && !cfg_mux_mode && !cfg_ff_src[b]) |=> (reg_out[b] == $past(side_in[b])));

        assert_mux_mode_lut_R8: assert property (@(posedge clk) disable iff (rst)
            (ce && cfg_mux_mode) |=> (reg_out[b] == $past(lut_val[b])));
    end

    assert_propagate_all_R6: assert property (@(posedge clk) disable iff (rst)
        ((cfg_chain_entry == '0) && (&cfg_mask)) |-> (carry_out == carry_in));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(reg_out));

    assert_clear_R10: assert property (@(posedge clk)
        rst |=> (reg_out == '0));

endmodule

bind slice_cell slice_cell_chk #(.NUM_BITS(NUM_BITS), .LUT_K(LUT_K)) chk_i (.*);

// File: tb/slice_cell_tb.sv
`timescale 1ns/1ps
module slice_cell_tb_top;
    localparam int NB = 2;
    localparam int K  = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   ce  = 1'b0;
    logic [NB-1:0][K-1:0]   lut_in = '0;
    logic [NB-1:0]          side_in = '0;
    logic                   carry_in = 1'b0;
    logic [NB-1:0][15:0]    cfg_mask = '0;
    logic [NB-1:0][1:0]     cfg_out_sel = '0;
    logic [NB-1:0]          cfg_ff_src = '0;
    logic [NB-1:0]          cfg_gen_sel = '0;
    logic [NB-1:0]          cfg_chain_entry = '0;
    logic                   cfg_mux_mode = 1'b0;
    logic [NB-1:0]          comb_out;
    logic [NB-1:0]          reg_out;
    logic                   carry_out;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    slice_cell #(.NUM_BITS(NB), .LUT_K(K)) dut_i (
        .clk, .rst, .ce, .lut_in, .side_in, .carry_in, .cfg_mask, .cfg_out_sel,
        .cfg_ff_src, .cfg_gen_sel, .cfg_chain_entry, .cfg_mux_mode,
        .comb_out, .reg_out, .carry_out
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        @(negedge clk);
        cfg_mask = '0; cfg_out_sel = '0; cfg_ff_src = '0; cfg_gen_sel = '0;
        cfg_chain_entry = '0; cfg_mux_mode = 1'b0; lut_in = '0; side_in = '0;
        carry_in = 1'b0; ce = 1'b0; rst = 1'b0;
    endtask

    function automatic logic [15:0] xor_mask();
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = i[0] ^ i[1];
        return m;
    endfunction

    task automatic t_reset();
        rst = 1'b1; ce = 1'b1; side_in = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset state", 16'(reg_out), 16'h0);
    endtask

    task automatic t_lut();
        logic [15:0] m0 = 16'hA5C3;
        logic [15:0] m1 = 16'h8116;
        defaults();
        cfg_mask[0] = m0; cfg_mask[1] = m1;
        cfg_out_sel[1] = 2'd3;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            lut_in[0] = 4'(i); lut_in[1] = ~4'(i);
            #1;
            chk("R1 lut bit0", 16'(comb_out[0]), 16'(m0[i]));
            chk("R1 lut bit1 alt code", 16'(comb_out[1]), 16'(m1[15-i]));
        end
    endtask

    task automatic t_mux(input logic mode);
        logic [3:0] d0 = 4'b0110;
        logic [3:0] d1 = 4'b1011;
        defaults();
        cfg_mux_mode = mode;
        cfg_out_sel = {2'd1, 2'd1};
        cfg_mask = {16'h0000, 16'hFFFF};
        lut_in[0] = d0; lut_in[1] = d1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            side_in = 2'(s);
            #1;
            chk(mode ? "R2 mux bit0" : "R3 mux bit0 normal mode", 16'(comb_out[0]), 16'(d0[s]));
            chk(mode ? "R2 mux bit1" : "R3 mux bit1 normal mode", 16'(comb_out[1]), 16'(d1[s]));
        end
    endtask

    task automatic t_adder();
        defaults();
        cfg_mask = {xor_mask(), xor_mask()};
        cfg_out_sel = {2'd2, 2'd2};
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 2; c++) begin
                    logic [2:0] s;
                    @(negedge clk);
                    lut_in[0] = {2'b00, 1'(b), 1'(a)};
                    lut_in[1] = {2'b00, 1'(b >> 1), 1'(a >> 1)};
                    carry_in = 1'(c);
                    s = 3'(a + b + c);
                    #1;
                    chk("R4 sum bits", 16'(comb_out), 16'(s[1:0]));
                    chk("R5 R6 ripple carry", 16'(carry_out), 16'(s[2]));
                end
    endtask

    task automatic t_chain_entry();
        defaults();
        cfg_mask = {xor_mask(), xor_mask()};
        cfg_out_sel = {2'd2, 2'd2};
        @(negedge clk);
        cfg_chain_entry = 2'b01; side_in = 2'b01; carry_in = 1'b0;
        lut_in[0] = 4'b0001; lut_in[1] = 4'b0000;
        #1;
        chk("R6 entry bit0 sum", 16'(comb_out), 16'h2);
        chk("R6 entry bit0 carry", 16'(carry_out), 16'h0);
        @(negedge clk);
        cfg_chain_entry = 2'b10; side_in = 2'b10; carry_in = 1'b0;
        lut_in[0] = 4'b0001; lut_in[1] = 4'b0001;
        #1;
        chk("R6 entry bit1 sum", 16'(comb_out), 16'h1);
        chk("R6 entry bit1 carry", 16'(carry_out), 16'h1);
    endtask

    task automatic t_generate();
        defaults();
        cfg_gen_sel = 2'b11;
        @(negedge clk);
        lut_in[1] = 4'b0010;
        #1;
        chk("R5 generate from input1 high", 16'(carry_out), 16'h1);
        @(negedge clk);
        lut_in[1] = 4'b0001;
        #1;
        chk("R5 generate from input1 low", 16'(carry_out), 16'h0);
        @(negedge clk);
        cfg_gen_sel = 2'b00;
        #1;
        chk("R5 generate from input0", 16'(carry_out), 16'h1);
    endtask

    task automatic t_ff_normal();
        defaults();
        ce = 1'b1;
        side_in = 2'b10;
        @(posedge clk); @(negedge clk);
        chk("R7 side load 10", 16'(reg_out), 16'h2);
        side_in = 2'b01;
        @(posedge clk); @(negedge clk);
        chk("R7 side load 01", 16'(reg_out), 16'h1);
        cfg_ff_src = 2'b11; cfg_mask = {16'h0000, 16'hFFFF}; side_in = 2'b10;
        @(posedge clk); @(negedge clk);
        chk("R7 lut load", 16'(reg_out), 16'h1);
    endtask

    task automatic t_ff_muxmode();
        defaults();
        ce = 1'b1; cfg_mux_mode = 1'b1; cfg_ff_src = 2'b00;
        cfg_mask = {16'h0000, 16'hFFFF}; side_in = 2'b10;
        @(posedge clk); @(negedge clk);
        chk("R8 lut load in select mode", 16'(reg_out), 16'h1);
        side_in = 2'b01;
        @(posedge clk); @(negedge clk);
        chk("R8 side change ignored", 16'(reg_out), 16'h1);
        cfg_mask = {16'hFFFF, 16'h0000};
        @(posedge clk); @(negedge clk);
        chk("R8 follows lut", 16'(reg_out), 16'h2);
    endtask

    task automatic t_hold_and_clear();
        defaults();
        ce = 1'b1; side_in = 2'b11;
        @(posedge clk); @(negedge clk);
        chk("R7 preload", 16'(reg_out), 16'h3);
        ce = 1'b0; side_in = 2'b00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 hold with ce low", 16'(reg_out), 16'h3);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 clear with ce low", 16'(reg_out), 16'h0);
        rst = 1'b0; ce = 1'b1; side_in = 2'b11;
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 clear beats enable", 16'(reg_out), 16'h0);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_lut();
        t_mux(1'b1);
        t_mux(1'b0);
        t_adder();
        t_chain_entry();
        t_generate();
        t_ff_normal();
        t_ff_muxmode();
        t_hold_and_clear();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule